// File: doc/BRIEF.md
# SMBus Quick Command Handler

This block runs the SMBus quick command from either end of the bus. A quick command carries no data phase. Its only data bit is the R/W bit of the address byte, and it is typically used to switch a target on or off.

On the initiating side, software loads a destination header (a 7-bit address and the R/W bit) and writes a launch code. The block then produces a start event, the header byte and a stop event, with a wait for the acknowledge result between the header and the stop.

On the responding side, the block consumes a byte-level bus event stream and always acknowledges its own address. It recognises a transfer that ends at a stop right after the acknowledge as a quick command, and reports it through status bits and interrupts. If the R/W bit was 1, the block asks software for a response byte. It stretches the following bit clock until that byte has been written, then drives bit 7 of the byte and releases the data line.

Both event streams use valid/ready.
- The master stream must hold its kind and byte stable while it waits for ready.
- The target side lowers `t_ev_ready` only while it waits for the response byte. This is its form of clock stretching.

Event kind codes are 0 = START, 1 = STOP, 2 = BYTE and 3 = BIT (one clock slot the target takes part in).

Top module: `qcmd_engine`

## Requirements
- R1: A register-0 write whose bits [2:0] are 111, made while idle, starts a transfer. The master emits START, then a BYTE equal to the register-1 value (address in bits [7:1], R/W in bit 0), waits for an acknowledge report, and emits STOP with no data byte. Busy (register 0 bit 0) is high from the cycle after the launch until the STOP is accepted.
- R2: An event transfers on a cycle with valid and ready both high. The master keeps `m_ev_valid`, kind and byte stable while ready is low. Event kind codes are 0 START, 1 STOP, 2 BYTE, 3 BIT.
- R3: When the acknowledge report has `m_ack_ok` = 0, the NACK bit (register 0 bit 1) is set, and it clears at the next launch. The master still emits STOP. The done interrupt (register 3 bit 2, `irq_mst_done`) rises in the cycle where busy falls.
- R4: A register-0 write with bits [2:0] other than 111 does not start a transfer. Neither does any launch write made while busy.
- R5: The target pulls the data line low (`t_sda_low`) from the acceptance of an address BYTE whose bits [7:1] equal `t_own_addr` until the next BIT is accepted. This holds for either R/W value and whether or not a response is ready. Any other address gives no pull and no interrupt.
- R6: The sequence START, own address with R/W 0, acknowledge BIT, STOP sets the quick bit (register 0 bit 2) to 1 and the direction bit (register 0 bit 3) to 0. It raises the stop interrupt (register 3 bit 1, `irq_tgt_stop`) and never the data interrupt.
- R7: Own address with R/W 1 raises the data interrupt (register 3 bit 0, `irq_tgt_data`) on the next cycle. After the acknowledge BIT, the target holds `t_ev_ready` low until software writes register 2. That write clears the data interrupt.
- R8: During the bit-7 slot, `t_sda_low` is the inverse of bit 7 of the loaded byte. It drops once that BIT is accepted. The STOP that follows sets both the quick and direction bits and raises the stop interrupt.
- R9: An accepted START clears the quick bit, the direction bit and any pending response request.
- R10: A BYTE after the acknowledge of a write address makes the transfer an ordinary one. Its STOP raises the stop interrupt and leaves the quick bit at 0.
- R11: A register-2 write made while no response is requested is ignored, and register 2 reads back unchanged.
- R12: Writing 1 to register 3 bit 1 or bit 2 clears the stop or done interrupt. A setting event in the same cycle wins. Register 1 reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_wr | input | 1 | Register write strobe |
| sw_addr | input | 2 | Register index |
| sw_wdata | input | 8 | Register write data |
| sw_rdata | output | 8 | Register read data (combinational on sw_addr) |
| m_ev_valid | output | 1 | Master event valid |
| m_ev_ready | input | 1 | Master event ready |
| m_ev_kind | output | 2 | Master event kind |
| m_ev_byte | output | 8 | Master header byte |
| m_ack_valid | input | 1 | Acknowledge report strobe |
| m_ack_ok | input | 1 | 1 = target acknowledged |
| m_busy | output | 1 | Master transfer in progress |
| t_own_addr | input | 7 | Target's own address |
| t_ev_valid | input | 1 | Target event valid |
| t_ev_ready | output | 1 | Target event ready (low = clock stretched) |
| t_ev_kind | input | 2 | Target event kind |
| t_ev_byte | input | 8 | Target event byte |
| t_sda_low | output | 1 | Target pulls data line low |
| irq_tgt_data | output | 1 | Response byte requested |
| irq_tgt_stop | output | 1 | Stop seen in an addressed transfer |
| irq_mst_done | output | 1 | Master quick command finished |

## Verification
The hardest state to reach is the stretched bit-7 slot of a read quick command. There the target holds a BIT event unaccepted while software is still due to supply the response byte. The bench reaches it by forking two processes. One offers the BIT event and waits on ready. The other waits a few cycles, checks that the slot is stalled and the request is up, and then writes the response. Using responses with bit 7 set and clear shows the driven level inside that slot and the release after it. A second launch written while the master waits for its acknowledge, together with a sink that withholds ready in a fixed pattern, covers the master's ignored-launch and hold rules.

// File: rtl/qcmd_pkg.sv
package qcmd_pkg;
  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_STOP  = 2'd1,
    EV_BYTE  = 2'd2,
    EV_BIT   = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    M_IDLE, M_START, M_HDR, M_WACK, M_STOP
  } mst_st_e;

  typedef enum logic [2:0] {
    T_IDLE, T_ADDR, T_ACK, T_BIT7, T_RSTOP, T_WSTOP, T_DATA
  } tgt_st_e;

  localparam logic [2:0] LAUNCH_CODE = 3'b111;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DEST = 2'd1;
  localparam logic [1:0] REG_RESP = 2'd2;
  localparam logic [1:0] REG_IRQ  = 2'd3;
endpackage

// File: rtl/qcmd_master.sv
module qcmd_master
  import qcmd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [BYTE_W-1:0] dest,
  output logic              ev_valid,
  input  logic              ev_ready,
  output ev_kind_e          ev_kind,
  output logic [BYTE_W-1:0] ev_byte,
  input  logic              ack_valid,
  input  logic              ack_ok,
  output logic              busy,
  output logic              nack,
  output logic              done
);
  mst_st_e           st;
  logic [BYTE_W-1:0] hdr_q;
  logic              nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= M_IDLE;
      hdr_q  <= '0;
      nack_q <= 1'b0;
    end else begin
      unique case (st)
        M_IDLE: if (launch) begin
          hdr_q  <= dest;
          nack_q <= 1'b0;
          st     <= M_START;
        end
        M_START: if (ev_ready) st <= M_HDR;
        M_HDR:   if (ev_ready) st <= M_WACK;
        M_WACK:  if (ack_valid) begin
          nack_q <= !ack_ok;
          st     <= M_STOP;
        end
        M_STOP:  if (ev_ready) st <= M_IDLE;
        default: st <= M_IDLE;
      endcase
    end
  end

  always_comb begin
    ev_valid = (st == M_START) || (st == M_HDR) || (st == M_STOP);
    case (st)
      M_START: ev_kind = EV_START;
      M_STOP:  ev_kind = EV_STOP;
      default: ev_kind = EV_BYTE;
    endcase
  end

  assign ev_byte = hdr_q;
  assign busy    = (st != M_IDLE);
  assign nack    = nack_q;
  assign done    = (st == M_STOP) && ev_ready;
endmodule

// File: rtl/qcmd_target.sv
module qcmd_target
  import qcmd_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  ev_kind_e          ev_kind,
  input  logic [BYTE_W-1:0] ev_byte,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              sda_low,
  output logic              data_req,
  output logic              stop_hit,
  output logic              qst,
  output logic              qrw,
  output logic [BYTE_W-1:0] resp
);
  tgt_st_e st;
  logic    rw_q, pend, loaded, accept, addressed;

  assign ev_ready  = !((st == T_BIT7) && !loaded);
  assign accept    = ev_valid && ev_ready;
  assign addressed = (st == T_ACK) || (st == T_BIT7) || (st == T_RSTOP) ||
                     (st == T_WSTOP) || (st == T_DATA);
  assign stop_hit  = accept && (ev_kind == EV_STOP) && addressed;
  assign sda_low   = (st == T_ACK) || ((st == T_BIT7) && loaded && !resp[BYTE_W-1]);
  assign data_req  = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      rw_q   <= 1'b0;
      pend   <= 1'b0;
      loaded <= 1'b0;
      resp   <= '0;
      qst    <= 1'b0;
      qrw    <= 1'b0;
    end else begin
      if (load_en && pend) begin
        resp   <= load_byte;
        loaded <= 1'b1;
        pend   <= 1'b0;
      end
      if (accept) begin
        unique case (ev_kind)
          EV_START: begin
            st     <= T_ADDR;
            qst    <= 1'b0;
            qrw    <= 1'b0;
            pend   <= 1'b0;
            loaded <= 1'b0;
          end
          EV_BYTE: begin
            if (st == T_ADDR) begin
              if (ev_byte[BYTE_W-1:1] == own_addr) begin
                st   <= T_ACK;
                rw_q <= ev_byte[0];
                pend <= ev_byte[0];
              end else begin
                st <= T_IDLE;
              end
            end else if (st == T_WSTOP) begin
              st <= T_DATA;
            end
          end
          EV_BIT: begin
            if (st == T_ACK) st <= rw_q ? T_BIT7 : T_WSTOP;
            else if (st == T_BIT7) st <= T_RSTOP;
          end
          EV_STOP: begin
            if (st == T_WSTOP) begin
              qst <= 1'b1;
              qrw <= 1'b0;
            end else if (st == T_RSTOP) begin
              qst <= 1'b1;
              qrw <= 1'b1;
            end
            st   <= T_IDLE;
            pend <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/qcmd_regs.sv
module qcmd_regs
  import qcmd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [RA_W-1:0]   sw_addr,
  input  logic [BYTE_W-1:0] sw_wdata,
  output logic [BYTE_W-1:0] sw_rdata,
  input  logic              m_busy,
  input  logic              m_nack,
  input  logic              m_done,
  input  logic              t_qst,
  input  logic              t_qrw,
  input  logic              t_req,
  input  logic              t_stop,
  input  logic [BYTE_W-1:0] t_resp,
  output logic [BYTE_W-1:0] dest,
  output logic              launch,
  output logic              load_en,
  output logic              irq_stop,
  output logic              irq_done
);
  logic wr_irq;

  assign launch  = sw_wr && (sw_addr == REG_CTRL) && (sw_wdata[2:0] == LAUNCH_CODE);
  assign load_en = sw_wr && (sw_addr == REG_RESP);
  assign wr_irq  = sw_wr && (sw_addr == REG_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest     <= '0;
      irq_stop <= 1'b0;
      irq_done <= 1'b0;
    end else begin
      if (sw_wr && (sw_addr == REG_DEST)) dest <= sw_wdata;
      if (wr_irq && sw_wdata[1]) irq_stop <= 1'b0;
      if (wr_irq && sw_wdata[2]) irq_done <= 1'b0;
      if (t_stop) irq_stop <= 1'b1;
      if (m_done) irq_done <= 1'b1;
    end
  end

  always_comb begin
    sw_rdata = '0;
    case (sw_addr)
      REG_CTRL: sw_rdata[3:0] = {t_qrw, t_qst, m_nack, m_busy};
      REG_DEST: sw_rdata = dest;
      REG_RESP: sw_rdata = t_resp;
      default:  sw_rdata[2:0] = {irq_done, irq_stop, t_req};
    endcase
  end
endmodule

// File: rtl/qcmd_engine.sv
module qcmd_engine
  import qcmd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int RA_W   = 2,
  localparam int ADDR_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [RA_W-1:0]   sw_addr,
  input  logic [BYTE_W-1:0] sw_wdata,
  output logic [BYTE_W-1:0] sw_rdata,
  output logic              m_ev_valid,
  input  logic              m_ev_ready,
  output logic [1:0]        m_ev_kind,
  output logic [BYTE_W-1:0] m_ev_byte,
  input  logic              m_ack_valid,
  input  logic              m_ack_ok,
  output logic              m_busy,
  input  logic [ADDR_W-1:0] t_own_addr,
  input  logic              t_ev_valid,
  output logic              t_ev_ready,
  input  logic [1:0]        t_ev_kind,
  input  logic [BYTE_W-1:0] t_ev_byte,
  output logic              t_sda_low,
  output logic              irq_tgt_data,
  output logic              irq_tgt_stop,
  output logic              irq_mst_done
);
  ev_kind_e          mk;
  logic              launch, load_en, m_nack, m_done;
  logic              tgt_qst, tgt_qrw, t_stop;
  logic [BYTE_W-1:0] dest, t_resp;

  assign m_ev_kind = mk;

  qcmd_regs #(.BYTE_W(BYTE_W), .RA_W(RA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .m_busy(m_busy),
    .m_nack(m_nack), .m_done(m_done), .t_qst(tgt_qst), .t_qrw(tgt_qrw),
    .t_req(irq_tgt_data), .t_stop(t_stop), .t_resp(t_resp), .dest(dest),
    .launch(launch), .load_en(load_en), .irq_stop(irq_tgt_stop),
    .irq_done(irq_mst_done)
  );

  qcmd_master #(.BYTE_W(BYTE_W)) mst_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .dest(dest),
    .ev_valid(m_ev_valid), .ev_ready(m_ev_ready), .ev_kind(mk),
    .ev_byte(m_ev_byte), .ack_valid(m_ack_valid), .ack_ok(m_ack_ok),
    .busy(m_busy), .nack(m_nack), .done(m_done)
  );

  qcmd_target #(.BYTE_W(BYTE_W)) tgt_i (
    .clk(clk), .rst_n(rst_n), .own_addr(t_own_addr), .ev_valid(t_ev_valid),
    .ev_ready(t_ev_ready), .ev_kind(ev_kind_e'(t_ev_kind)), .ev_byte(t_ev_byte),
    .load_en(load_en), .load_byte(sw_wdata), .sda_low(t_sda_low),
    .data_req(irq_tgt_data), .stop_hit(t_stop), .qst(tgt_qst), .qrw(tgt_qrw),
    .resp(t_resp)
  );
endmodule

// File: rtl/qcmd_checker.sv
module qcmd_checker #(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_ev_valid,
  input logic              m_ev_ready,
  input logic [1:0]        m_ev_kind,
  input logic [BYTE_W-1:0] m_ev_byte,
  input logic              m_busy,
  input logic              t_ev_valid,
  input logic              t_ev_ready,
  input logic [1:0]        t_ev_kind,
  input logic [BYTE_W-1:0] t_ev_byte,
  input logic [ADDR_W-1:0] t_own_addr,
  input logic              t_sda_low,
  input logic              irq_tgt_data,
  input logic              irq_mst_done,
  input logic              tgt_qst,
  input logic              tgt_qrw
);
  a_r2_hold_event: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ev_valid && !m_ev_ready) |=>
      (m_ev_valid && $stable(m_ev_kind) && $stable(m_ev_byte)));

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !m_busy |-> !m_ev_valid);

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_mst_done) |-> !m_busy);

  a_r7_stall_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !t_ev_ready |-> irq_tgt_data);

  a_r6_write_quick_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_qst && !tgt_qrw) |-> !irq_tgt_data);

  a_r5_foreign_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (t_ev_valid && t_ev_ready && (t_ev_kind == 2'd2) &&
     (t_ev_byte[BYTE_W-1:1] != t_own_addr) && !t_sda_low) |=> !t_sda_low);
endmodule

bind qcmd_engine qcmd_checker #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .m_ev_valid(m_ev_valid), .m_ev_ready(m_ev_ready),
  .m_ev_kind(m_ev_kind), .m_ev_byte(m_ev_byte), .m_busy(m_busy),
  .t_ev_valid(t_ev_valid), .t_ev_ready(t_ev_ready), .t_ev_kind(t_ev_kind),
  .t_ev_byte(t_ev_byte), .t_own_addr(t_own_addr), .t_sda_low(t_sda_low),
  .irq_tgt_data(irq_tgt_data), .irq_mst_done(irq_mst_done),
  .tgt_qst(tgt_qst), .tgt_qrw(tgt_qrw)
);

// File: tb/qcmd_engine_tb_top.sv
`timescale 1ns/1ps
module qcmd_engine_tb_top;
  logic clk = 0, rst_n = 0;
  logic sw_wr = 0; logic [1:0] sw_addr = 0; logic [7:0] sw_wdata = 0;
  logic [7:0] sw_rdata;
  logic m_ev_valid, m_ev_ready = 0, m_ack_valid = 0, m_ack_ok = 0, m_busy;
  logic [1:0] m_ev_kind; logic [7:0] m_ev_byte;
  logic [6:0] t_own_addr = 7'h2A;
  logic t_ev_valid = 0, t_ev_ready; logic [1:0] t_ev_kind = 0; logic [7:0] t_ev_byte = 0;
  logic t_sda_low, irq_tgt_data, irq_tgt_stop, irq_mst_done;

  int checks = 0, errors = 0, pcnt = 0;
  logic [9:0] evq[$];

  qcmd_engine dut_i (.*);

  always #2.5 clk = ~clk;

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int mph, tph; logic mnack, tpend, tload, trw, tqs, tqr, xi_stop, xi_done, acc;
  logic [7:0] mbyte, tresp, xdest;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph <= 0; tph <= 0; mnack <= 0; tpend <= 0; tload <= 0; trw <= 0;
      tqs <= 0; tqr <= 0; xi_stop <= 0; xi_done <= 0; mbyte <= 0; tresp <= 0; xdest <= 0;
    end else begin
      if (sw_wr && sw_addr == 1) xdest <= sw_wdata;
      if (sw_wr && sw_addr == 3 && sw_wdata[1]) xi_stop <= 0;
      if (sw_wr && sw_addr == 3 && sw_wdata[2]) xi_done <= 0;
      case (mph)
        0: if (sw_wr && sw_addr == 0 && sw_wdata[2:0] == 3'b111) begin
             mbyte <= xdest; mnack <= 0; mph <= 1; end
        1: if (m_ev_ready) mph <= 2;
        2: if (m_ev_ready) mph <= 3;
        3: if (m_ack_valid) begin mnack <= !m_ack_ok; mph <= 4; end
        default: if (m_ev_ready) begin mph <= 0; xi_done <= 1; end
      endcase
      acc = t_ev_valid && !(tph == 3 && !tload);
      if (sw_wr && sw_addr == 2 && tpend) begin tresp <= sw_wdata; tload <= 1; tpend <= 0; end
      if (acc) begin
        if (t_ev_kind == 0) begin tph <= 1; tqs <= 0; tqr <= 0; tpend <= 0; tload <= 0; end
        else if (t_ev_kind == 2) begin
          if (tph == 1) begin
            if (t_ev_byte[7:1] == t_own_addr) begin
              tph <= 2; trw <= t_ev_byte[0]; tpend <= t_ev_byte[0];
            end else tph <= 0;
          end else if (tph == 5) tph <= 6;
        end else if (t_ev_kind == 3) begin
          if (tph == 2) tph <= trw ? 3 : 5;
          else if (tph == 3) tph <= 4;
        end else begin
          if (tph >= 2) xi_stop <= 1;
          if (tph == 5) begin tqs <= 1; tqr <= 0; end
          if (tph == 4) begin tqs <= 1; tqr <= 1; end
          tph <= 0; tpend <= 0;
        end
      end
    end
  end

  // per-cycle comparison, away from the clock edge
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      logic [7:0] erd;
      case (sw_addr)
        0: erd = {4'b0, tqr, tqs, mnack, mph != 0};
        1: erd = xdest;
        2: erd = tresp;
        default: erd = {5'b0, xi_done, xi_stop, tpend};
      endcase
      cmp("R12 sw_rdata", sw_rdata, erd);
      cmp("R1 m_busy", m_busy, mph != 0);
      cmp("R2 m_ev_valid", m_ev_valid, mph == 1 || mph == 2 || mph == 4);
      if (m_ev_valid) begin
        cmp("R2 m_ev_kind", m_ev_kind, mph == 1 ? 0 : (mph == 4 ? 1 : 2));
        cmp("R2 m_ev_byte", m_ev_byte, mbyte);
      end
      cmp("R7 t_ev_ready", t_ev_ready, !(tph == 3 && !tload));
      cmp("R5 t_sda_low", t_sda_low, tph == 2 || (tph == 3 && tload && !tresp[7]));
      cmp("R7 irq_tgt_data", irq_tgt_data, tpend);
      cmp("R12 irq_tgt_stop", irq_tgt_stop, xi_stop);
      cmp("R3 irq_mst_done", irq_mst_done, xi_done);
      if (m_ev_valid && m_ev_ready) evq.push_back({m_ev_kind, m_ev_byte});
    end
  end

  always @(negedge clk) begin
    m_ev_ready = (pcnt % 3) != 1;
    pcnt++;
  end

  task automatic sw_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sw_wr = 1; sw_addr = a; sw_wdata = d;
    @(negedge clk); sw_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); sw_addr = a; #1; v = sw_rdata;
  endtask

  task automatic t_send(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk); t_ev_valid = 1; t_ev_kind = k; t_ev_byte = b; #1;
    while (!t_ev_ready) begin @(negedge clk); #1; end
    @(negedge clk); t_ev_valid = 0; #1;
  endtask

  task automatic master_run(input logic ok, input logic relaunch);
    evq.delete();
    sw_write(0, 8'h07);
    do @(negedge clk); while (evq.size() < 2);
    if (relaunch) begin
      sw_write(0, 8'h07);   // busy: must be ignored
    end
    @(negedge clk); m_ack_valid = 1; m_ack_ok = ok;
    @(negedge clk); m_ack_valid = 0;
    do @(negedge clk); while (m_busy);
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic read_quick(input logic [7:0] rv);
    t_send(0, 8'h00);
    t_send(2, {7'h2A, 1'b1});
    cmp("R7 data request raised", irq_tgt_data, 1);
    cmp("R5 ack on read address", t_sda_low, 1);
    t_send(3, 8'h00);
    fork
      t_send(3, 8'h00);
      begin
        repeat (3) @(negedge clk); #1;
        cmp("R7 bit clock stalled", t_ev_ready, 0);
        cmp("R7 request still up", irq_tgt_data, 1);
        sw_write(2, rv); #1;
        cmp("R7 load clears request", irq_tgt_data, 0);
        cmp("R8 bit7 drive", t_sda_low, !rv[7]);
      end
    join
    cmp("R8 release after bit7", t_sda_low, 0);
    t_send(1, 8'h00);
  endtask

  initial begin : main
    logic [7:0] v;
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        cmp("R1 reset busy", m_busy, 0);
        cmp("R12 reset irqs", {irq_tgt_data, irq_tgt_stop, irq_mst_done}, 0);
        // master: ignored launch code
        sw_write(0, 8'h03);
        repeat (3) @(negedge clk); #1;
        cmp("R4 bad code ignored", m_busy, 0);
        // master: acked quick command, second launch while busy
        sw_write(1, {7'h50, 1'b0});
        rd(1, v); cmp("R12 dest readback", v, 8'hA0);
        master_run(1, 1);
        cmp("R4 one transfer only", evq.size(), 3);
        cmp("R1 first START", evq[0][9:8], 0);
        cmp("R1 header byte", evq[1][7:0], 8'hA0);
        cmp("R1 header kind", evq[1][9:8], 2);
        cmp("R1 ends with STOP", evq[2][9:8], 1);
        cmp("R3 done raised", irq_mst_done, 1);
        rd(0, v); cmp("R3 nack clear", v[1], 0);
        sw_write(3, 8'h04); #1;
        cmp("R12 done cleared", irq_mst_done, 0);
        // master: nacked
        sw_write(1, {7'h11, 1'b1});
        master_run(0, 0);
        cmp("R3 stop after nack", evq.size() == 3 ? evq[2][9:8] : 2'd3, 1);
        cmp("R1 read header", evq[1][7:0], 8'h23);
        rd(0, v); cmp("R3 nack flag", v[1], 1);
        sw_write(3, 8'h04);
        // target: write quick command
        t_send(0, 8'h00);
        t_send(2, {7'h2A, 1'b0});
        cmp("R5 ack own address", t_sda_low, 1);
        t_send(3, 8'h00);
        cmp("R5 ack released", t_sda_low, 0);
        t_send(1, 8'h00);
        cmp("R6 stop irq", irq_tgt_stop, 1);
        cmp("R6 no data irq", irq_tgt_data, 0);
        rd(0, v); cmp("R6 quick=1 dir=0", v & 8'h0C, 8'h04);
        sw_write(3, 8'h02); #1;
        cmp("R12 stop cleared", irq_tgt_stop, 0);
        // stray response write
        sw_write(2, 8'h12);
        rd(2, v); cmp("R11 stray load ignored", v, 8'h00);
        // target: read quick with 0xFF, START clearing first
        fork
          read_quick(8'hFF);
          begin
            @(negedge clk); @(negedge clk); #1;
          end
        join
        cmp("R8 stop irq read", irq_tgt_stop, 1);
        rd(0, v); cmp("R8 quick=1 dir=1", v & 8'h0C, 8'h0C);
        rd(2, v); cmp("R8 response stored", v, 8'hFF);
        sw_write(3, 8'h02);
        t_send(0, 8'h00);
        rd(0, v); cmp("R9 start clears status", v & 8'h0C, 8'h00);
        t_send(1, 8'h00);
        // read quick with bit 7 clear
        read_quick(8'h7F);
        sw_write(3, 8'h02);
        // foreign address
        t_send(0, 8'h00);
        t_send(2, {7'h15, 1'b1});
        cmp("R5 foreign no ack", t_sda_low, 0);
        cmp("R5 foreign no request", irq_tgt_data, 0);
        t_send(1, 8'h00);
        cmp("R5 foreign no stop irq", irq_tgt_stop, 0);
        // ordinary write with data byte
        t_send(0, 8'h00);
        t_send(2, {7'h2A, 1'b0});
        t_send(3, 8'h00);
        t_send(2, 8'h33);
        t_send(1, 8'h00);
        cmp("R10 stop irq on data write", irq_tgt_stop, 1);
        rd(0, v); cmp("R10 not quick", v & 8'h0C, 8'h00);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule